// File: doc/BRIEF.md
# VME Single-Cycle Master Engine

This block sits behind a Wishbone slave port and turns each Wishbone read or write into one VME single data-transfer cycle. The upper nibble of the Wishbone address picks an access window. The window decides the VME address space (A16, A24, A32 or configuration space) and the widest data width allowed. The byte selects can narrow that width to D8 or D16. Requests outside the windows, and misaligned requests, are refused with a Wishbone error and never reach the bus.

On the VME side the block drives a reduced master pin set: address, address modifier, address strobe, two data strobes, the write line and the long-word line. It also drives the data bus and its output enable. After asserting the strobes it waits for the slave to acknowledge or to signal a bus error. A cycle counter ends the cycle if neither arrives. Configuration-space accesses are built as A24-type cycles, and their slot base comes from the inverted geographical address pins.

Top module: `vme_single_master`

## Requirements
- R1: Window = wb_adr_i[31:28]: 0 is A16/D16 (VME address = adr[15:0]), 1 is A16/D32, 2 is A24/D16 (adr[23:0]), 3 is A24/D32, 4 is A32/D32 (adr[27:0], upper four bits zero), 5 is configuration space; any other value gets wb_err_o and no VME cycle.
- R2: The address modifier is 0x29 for A16, 0x39 for A24, 0x09 for A32 and 0x2F for configuration space.
- R3: A configuration-space access drives VME address {~ga_n_i[4:0], wb_adr_i[18:0]} with the upper 8 bits zero.
- R4: wb_sel_i = 4'b0001 selects D8, 4'b0011 selects D16, and any other value selects the window's width (D16 for windows 0 and 2, D32 otherwise).
- R5: D8 at an even address asserts only vme_ds_n_o[1] (ds_n = 2'b01), and D8 at an odd address asserts only vme_ds_n_o[0] (2'b10). D16 and D32 assert both strobes. vme_lword_n_o is low for D32 cycles only. vme_adr_o[0] is always 0.
- R6: Byte lanes: D8 even uses bus bits [15:8], D8 odd uses [7:0], D16 uses [15:0] and D32 uses [31:0]. Wishbone data is LSB-justified and read data is zero-extended.
- R7: D16 at an odd VME address, or D32 with address bits [1:0] not zero, gets wb_err_o and no VME cycle.
- R8: Address, modifier and write line are set one cycle before the address strobe falls. The data strobes fall one cycle after it. Data strobes are never active without the address strobe.
- R9: A slave acknowledge gives a one-cycle wb_ack_o. In that cycle both strobes are already released. Read data is updated from the bus.
- R10: A slave bus error gives wb_err_o and leaves wb_dat_o unchanged. It takes priority over an acknowledge seen in the same cycle.
- R11: If neither response arrives, the data strobes stay active for exactly TIMEOUT_CYC cycles and the access ends with wb_err_o.
- R12: No new address strobe is asserted while the slave still holds acknowledge or bus error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 32 | Wishbone byte address, window in bits 31:28 |
| wb_sel_i | input | 4 | Wishbone byte selects, pick D8/D16 |
| wb_dat_i | input | 32 | Wishbone write data, LSB-justified |
| wb_dat_o | output | 32 | Read data, held until the next good read |
| wb_ack_o | output | 1 | Successful completion |
| wb_err_o | output | 1 | Error completion |
| ga_n_i | input | 5 | Geographical address pins, active low |
| vme_adr_o | output | 32 | VME address |
| vme_am_o | output | 6 | Address modifier |
| vme_as_n_o | output | 1 | Address strobe, active low |
| vme_ds_n_o | output | 2 | Data strobes, active low |
| vme_write_n_o | output | 1 | Write line, low for writes |
| vme_lword_n_o | output | 1 | Long-word line, low for D32 |
| vme_dat_o | output | 32 | VME data driven on writes |
| vme_dat_oe_o | output | 1 | Data output enable |
| vme_dat_i | input | 32 | VME data from the bus |
| vme_dtack_n_i | input | 1 | Slave acknowledge, active low |
| vme_berr_n_i | input | 1 | Bus error, active low |

## Verification
A wrong decode or a stale width register shows up on the first affected access, in the modifier, address or strobe pattern the slave model captures when the data strobes fall. A sequencer stuck in a wait state appears as a missing Wishbone response, or as an address strobe falling while the slave still holds acknowledge. A bad timeout count changes the measured strobe length of a silent cycle. Corrupted read data shows on the same response for good reads. After a bus error or refused access it shows as a changed hold value.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int VME_AW  = 32;
    localparam int VME_DW  = 32;
    localparam int AM_W    = 6;
    localparam int GA_W    = 5;
    localparam int CSR_OFS = 19;
    localparam int SEL_W   = VME_DW / 8;

    typedef enum logic [1:0] {
        SP_A16 = 2'd0,
        SP_A24 = 2'd1,
        SP_A32 = 2'd2,
        SP_CSR = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        DW_8  = 2'd0,
        DW_16 = 2'd1,
        DW_32 = 2'd2
    } width_e;

    typedef struct packed {
        logic              hit;
        logic              misalign;
        space_e            space;
        width_e            width;
        logic [VME_AW-1:0] vadr;
    } decode_t;

    function automatic logic [AM_W-1:0] am_code(space_e sp);
        case (sp)
            SP_A16:  am_code = 6'h29;
            SP_A24:  am_code = 6'h39;
            SP_A32:  am_code = 6'h09;
            default: am_code = 6'h2F;
        endcase
    endfunction

endpackage

// File: rtl/vsm_window_decode.sv
module vsm_window_decode
    import vsm_pkg::*;
(
    input  logic [31:0]      adr,
    input  logic [SEL_W-1:0] sel,
    input  logic [GA_W-1:0]  ga_n,
    output decode_t          dec
);
    localparam int CSR_TOP = VME_AW - GA_W - CSR_OFS;

    width_e max_w;

    always_comb begin
        dec.hit   = 1'b1;
        dec.space = SP_A16;
        dec.vadr  = '0;
        max_w     = DW_16;
        case (adr[31:28])
            4'd0: begin dec.space = SP_A16; max_w = DW_16; dec.vadr = {16'h0, adr[15:0]}; end
            4'd1: begin dec.space = SP_A16; max_w = DW_32; dec.vadr = {16'h0, adr[15:0]}; end
            4'd2: begin dec.space = SP_A24; max_w = DW_16; dec.vadr = {8'h0, adr[23:0]}; end
            4'd3: begin dec.space = SP_A24; max_w = DW_32; dec.vadr = {8'h0, adr[23:0]}; end
            4'd4: begin dec.space = SP_A32; max_w = DW_32; dec.vadr = {4'h0, adr[27:0]}; end
            4'd5: begin
                dec.space = SP_CSR;
                max_w     = DW_32;
                dec.vadr  = {{CSR_TOP{1'b0}}, ~ga_n, adr[CSR_OFS-1:0]};
            end
            default: dec.hit = 1'b0;
        endcase

        if (sel == 4'b0001)      dec.width = DW_8;
        else if (sel == 4'b0011) dec.width = DW_16;
        else                     dec.width = max_w;

        dec.misalign = ((dec.width == DW_16) && dec.vadr[0]) ||
                       ((dec.width == DW_32) && (dec.vadr[1:0] != 2'b00));
    end

endmodule

// File: rtl/vsm_lanes.sv
module vsm_lanes
    import vsm_pkg::*;
(
    input  width_e            width,
    input  logic              a0,
    input  logic [VME_DW-1:0] wdat,
    input  logic [VME_DW-1:0] bus_i,
    output logic [VME_DW-1:0] bus_o,
    output logic [VME_DW-1:0] rdat,
    output logic [1:0]        ds_pat_n,
    output logic              lword_n
);
    always_comb begin
        lword_n = 1'b1;
        case (width)
            DW_8: begin
                if (a0) begin
                    ds_pat_n = 2'b10;
                    bus_o    = {24'h0, wdat[7:0]};
                    rdat     = {24'h0, bus_i[7:0]};
                end else begin
                    ds_pat_n = 2'b01;
                    bus_o    = {16'h0, wdat[7:0], 8'h0};
                    rdat     = {24'h0, bus_i[15:8]};
                end
            end
            DW_16: begin
                ds_pat_n = 2'b00;
                bus_o    = {16'h0, wdat[15:0]};
                rdat     = {16'h0, bus_i[15:0]};
            end
            default: begin
                ds_pat_n = 2'b00;
                lword_n  = 1'b0;
                bus_o    = wdat;
                rdat     = bus_i;
            end
        endcase
    end

endmodule

// File: rtl/vsm_sync.sv
module vsm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/vme_single_master.sv
module vme_single_master
    import vsm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [31:0]       wb_adr_i,
    input  logic [SEL_W-1:0]  wb_sel_i,
    input  logic [VME_DW-1:0] wb_dat_i,
    output logic [VME_DW-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic              wb_err_o,
    input  logic [GA_W-1:0]   ga_n_i,
    output logic [VME_AW-1:0] vme_adr_o,
    output logic [AM_W-1:0]   vme_am_o,
    output logic              vme_as_n_o,
    output logic [1:0]        vme_ds_n_o,
    output logic              vme_write_n_o,
    output logic              vme_lword_n_o,
    output logic [VME_DW-1:0] vme_dat_o,
    output logic              vme_dat_oe_o,
    input  logic [VME_DW-1:0] vme_dat_i,
    input  logic              vme_dtack_n_i,
    input  logic              vme_berr_n_i
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ASTB,
        ST_DSTB,
        ST_REL
    } state_e;

    typedef struct packed {
        state_e            st;
        logic              cyc;
        logic              as_n;
        logic              ds_en;
        logic [VME_AW-1:0] adr;
        logic [AM_W-1:0]   am;
        width_e            width;
        logic              we;
        logic [VME_DW-1:0] wdat;
        logic              ack;
        logic              err;
        logic [VME_DW-1:0] rdat;
        logic [TO_W-1:0]   cnt;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:    ST_IDLE,
        cyc:   1'b0,
        as_n:  1'b1,
        ds_en: 1'b0,
        adr:   '0,
        am:    '0,
        width: DW_32,
        we:    1'b0,
        wdat:  '0,
        ack:   1'b0,
        err:   1'b0,
        rdat:  '0,
        cnt:   '0
    };

    regs_t   q, d;
    decode_t dec;
    logic    dtack_s_n, berr_s_n;
    logic [VME_DW-1:0] lane_bus, lane_rdat;
    logic [1:0]        lane_ds_n;
    logic              lane_lword_n;

    vsm_window_decode u_dec (
        .adr  (wb_adr_i),
        .sel  (wb_sel_i),
        .ga_n (ga_n_i),
        .dec  (dec)
    );

    vsm_lanes u_lanes (
        .width    (q.width),
        .a0       (q.adr[0]),
        .wdat     (q.wdat),
        .bus_i    (vme_dat_i),
        .bus_o    (lane_bus),
        .rdat     (lane_rdat),
        .ds_pat_n (lane_ds_n),
        .lword_n  (lane_lword_n)
    );

    vsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dtack (
        .clk (clk), .rst_n (rst_n), .d (vme_dtack_n_i), .q (dtack_s_n)
    );

    vsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_berr (
        .clk (clk), .rst_n (rst_n), .d (vme_berr_n_i), .q (berr_s_n)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (wb_cyc_i && wb_stb_i) begin
                    if (!dec.hit || dec.misalign) begin
                        d.err = 1'b1;
                        d.st  = ST_REL;
                    end else begin
                        d.adr   = dec.vadr;
                        d.am    = am_code(dec.space);
                        d.width = dec.width;
                        d.we    = wb_we_i;
                        d.wdat  = wb_dat_i;
                        d.cyc   = 1'b1;
                        d.st    = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                d.as_n = 1'b0;
                d.st   = ST_ASTB;
            end
            ST_ASTB: begin
                d.ds_en = 1'b1;
                d.cnt   = '0;
                d.st    = ST_DSTB;
            end
            ST_DSTB: begin
                if (!berr_s_n || !dtack_s_n || (q.cnt == TO_W'(TIMEOUT_CYC - 1))) begin
                    d.as_n  = 1'b1;
                    d.ds_en = 1'b0;
                    d.cyc   = 1'b0;
                    d.st    = ST_REL;
                    if (berr_s_n && !dtack_s_n) begin
                        d.ack = 1'b1;
                        if (!q.we) d.rdat = lane_rdat;
                    end else begin
                        d.err = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REL: begin
                if (dtack_s_n && berr_s_n) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign wb_dat_o      = q.rdat;
    assign wb_ack_o      = q.ack;
    assign wb_err_o      = q.err;
    assign vme_adr_o     = {q.adr[VME_AW-1:1], 1'b0};
    assign vme_am_o      = q.am;
    assign vme_as_n_o    = q.as_n;
    assign vme_ds_n_o    = q.ds_en ? lane_ds_n : 2'b11;
    assign vme_write_n_o = ~(q.cyc & q.we);
    assign vme_lword_n_o = q.cyc ? lane_lword_n : 1'b1;
    assign vme_dat_o     = lane_bus;
    assign vme_dat_oe_o  = q.cyc & q.we;

endmodule

// File: rtl/vsm_checker.sv
module vsm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        as_n,
    input logic [1:0]  ds_n,
    input logic        lword_n,
    input logic [5:0]  am,
    input logic [31:0] adr,
    input logic        ack,
    input logic        err
);
    p_ds_inside_as_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_n != 2'b11) |-> !as_n);

    p_as_leads_ds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ds_n != 2'b11) && ($past(ds_n) == 2'b11)) |-> !$past(as_n));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !$past(as_n)) |-> ($stable(am) && $stable(adr)));

    p_lword_both_ds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ds_n != 2'b11) && !lword_n) |-> (ds_n == 2'b00));

    p_single_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err));

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_resp_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || err) |-> (as_n && (ds_n == 2'b11)));

    p_ack_after_ds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(ds_n) != 2'b11));

    p_adr_a0_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adr[0]);
endmodule

bind vme_single_master vsm_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (vme_as_n_o),
    .ds_n    (vme_ds_n_o),
    .lword_n (vme_lword_n_o),
    .am      (vme_am_o),
    .adr     (vme_adr_o),
    .ack     (wb_ack_o),
    .err     (wb_err_o)
);

// File: tb/tb_vme_single_master.sv
`timescale 1ns/1ps
module tb_vme_single_master;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [31:0] wb_adr = 0, wb_wdat = 0;
    logic [3:0]  wb_sel = 0;
    logic [31:0] wb_rdat;
    logic        wb_ack, wb_err;
    logic [4:0]  ga_n = 5'b11100;
    logic [31:0] v_adr, v_dat_o;
    logic [5:0]  v_am;
    logic        v_as_n, v_write_n, v_lword_n, v_oe;
    logic [1:0]  v_ds_n;
    logic [31:0] slv_rdata = 0;
    logic        dtack_n = 1'b1, berr_n = 1'b1;

    always #5 clk = ~clk;

    vme_single_master #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we),
        .wb_adr_i(wb_adr), .wb_sel_i(wb_sel), .wb_dat_i(wb_wdat),
        .wb_dat_o(wb_rdat), .wb_ack_o(wb_ack), .wb_err_o(wb_err),
        .ga_n_i(ga_n),
        .vme_adr_o(v_adr), .vme_am_o(v_am), .vme_as_n_o(v_as_n),
        .vme_ds_n_o(v_ds_n), .vme_write_n_o(v_write_n), .vme_lword_n_o(v_lword_n),
        .vme_dat_o(v_dat_o), .vme_dat_oe_o(v_oe), .vme_dat_i(slv_rdata),
        .vme_dtack_n_i(dtack_n), .vme_berr_n_i(berr_n)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // slave model
    int          slv_mode = 0;   // 0 dtack, 1 berr, 2 silent
    int          slv_delay = 1, slv_hold = 0;
    int          slv_cnt = 0, r12_viol = 0, ds_run = 0, ds_len = 0;
    logic [31:0] cap_adr, cap_dat;
    logic [5:0]  cap_am;
    logic [1:0]  cap_ds;
    logic        cap_lword, cap_write_n, cap_order_ok;

    initial begin
        int   phase = 0, cd = 0;
        logic as_prev = 1'b1;
        logic [1:0] ds_prev = 2'b11;
        forever begin
            @(negedge clk);
            if (!v_as_n && as_prev && (!dtack_n || !berr_n)) r12_viol++;
            if (v_ds_n != 2'b11) ds_run++;
            else if (ds_run != 0) begin ds_len = ds_run; ds_run = 0; end
            case (phase)
                0: if (!v_as_n && v_ds_n != 2'b11) begin
                    cap_adr = v_adr; cap_am = v_am; cap_ds = v_ds_n;
                    cap_lword = v_lword_n; cap_write_n = v_write_n;
                    cap_dat = v_oe ? v_dat_o : 32'hx;
                    cap_order_ok = !as_prev && (ds_prev == 2'b11);
                    slv_cnt++;
                    cd = slv_delay;
                    phase = 1;
                end
                1: if (cd == 0) begin
                    if (slv_mode == 0) dtack_n = 1'b0;
                    else if (slv_mode == 1) berr_n = 1'b0;
                    phase = 2;
                end else cd--;
                2: if (v_as_n) begin
                    if (slv_hold == 0) begin
                        dtack_n = 1'b1; berr_n = 1'b1; phase = 0;
                    end else begin
                        cd = slv_hold; phase = 3;
                    end
                end
                default: begin
                    cd--;
                    if (cd == 0) begin dtack_n = 1'b1; berr_n = 1'b1; phase = 0; end
                end
            endcase
            as_prev = v_as_n;
            ds_prev = v_ds_n;
        end
    end

    // scoreboard
    typedef struct packed {
        logic        err;
        logic        cyc;
        logic        we;
        logic [31:0] rdat;
        logic [31:0] adr;
        logic [5:0]  am;
        logic [1:0]  ds;
        logic        lword;
        logic [31:0] vdat;
    } exp_t;

    exp_t        sb_q[$];
    string       tag_q[$];
    logic [31:0] model_rd = 0;
    int          last_cnt = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (wb_ack || wb_err) begin
                exp_t  e;
                string t;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", {30'h0, wb_ack, wb_err}, 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    chk(wb_err == e.err, {t, " error flag"}, {31'h0, wb_err}, {31'h0, e.err});
                    chk(wb_ack == !e.err, {t, " R9 ack flag"}, {31'h0, wb_ack}, {31'h0, !e.err});
                    chk(wb_rdat == e.rdat, {t, " R6/R10 read data"}, wb_rdat, e.rdat);
                    chk((slv_cnt - last_cnt) == (e.cyc ? 1 : 0), {t, " bus cycle count"},
                        slv_cnt - last_cnt, {31'h0, e.cyc});
                    if (e.cyc) begin
                        chk(cap_adr == e.adr, {t, " R1/R3 address"}, cap_adr, e.adr);
                        chk(cap_am == e.am, {t, " R2 modifier"}, {26'h0, cap_am}, {26'h0, e.am});
                        chk(cap_ds == e.ds, {t, " R5 strobes"}, {30'h0, cap_ds}, {30'h0, e.ds});
                        chk(cap_lword == e.lword, {t, " R5 lword"}, {31'h0, cap_lword}, {31'h0, e.lword});
                        chk(cap_write_n == !e.we, {t, " R8 write line"}, {31'h0, cap_write_n}, {31'h0, !e.we});
                        chk(cap_order_ok, {t, " R8 strobe order"}, {31'h0, cap_order_ok}, 32'h1);
                        if (e.we) chk(cap_dat == e.vdat, {t, " R6 write lanes"}, cap_dat, e.vdat);
                    end
                    last_cnt = slv_cnt;
                end
            end
        end
    end

    task automatic access(input string tag, input logic we, input logic [31:0] adr,
                          input logic [3:0] sel, input logic [31:0] wd, input logic [31:0] bus_rd,
                          input logic exp_err, input logic exp_cyc, input logic [31:0] e_adr,
                          input logic [5:0] e_am, input logic [1:0] e_ds, input logic e_lw,
                          input logic [31:0] e_vdat, input logic [31:0] e_rd);
        exp_t e;
        if (!we && !exp_err) model_rd = e_rd;
        e = '{err: exp_err, cyc: exp_cyc, we: we, rdat: model_rd, adr: e_adr,
              am: e_am, ds: e_ds, lword: e_lw, vdat: e_vdat};
        sb_q.push_back(e);
        tag_q.push_back(tag);
        slv_rdata = bus_rd;
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_sel = sel; wb_wdat = wd;
        do @(negedge clk); while (!(wb_ack || wb_err));
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(v_as_n && v_ds_n == 2'b11 && !wb_ack && !wb_err && v_write_n && !v_oe,
            "R8 reset idle pins", {26'h0, v_as_n, v_ds_n, wb_ack, wb_err, v_oe}, 32'h38);
        rst_n = 1;
        repeat (2) @(negedge clk);

        access("R1 A16D16 write", 1, 32'h0000_1234, 4'b0011, 32'h0000_BEEF, 0, 0, 1,
               32'h0000_1234, 6'h29, 2'b00, 1, 32'h0000_BEEF, 0);
        access("R4 A16 D16-window full sel read", 0, 32'h0000_0010, 4'b1111, 0, 32'hCAFE_1234, 0, 1,
               32'h0000_0010, 6'h29, 2'b00, 1, 0, 32'h0000_1234);
        access("R1 A16D32 read", 0, 32'h1000_0020, 4'b1111, 0, 32'h89AB_CDEF, 0, 1,
               32'h0000_0020, 6'h29, 2'b00, 0, 0, 32'h89AB_CDEF);
        access("R4 A24 D8 even write", 1, 32'h2012_3456, 4'b0001, 32'h0000_00A5, 0, 0, 1,
               32'h0012_3456, 6'h39, 2'b01, 1, 32'h0000_A500, 0);
        access("R6 A24 D8 odd read", 0, 32'h3000_0101, 4'b0001, 0, 32'h1122_3344, 0, 1,
               32'h0000_0100, 6'h39, 2'b10, 1, 0, 32'h0000_0044);
        access("R6 A24 D8 even read", 0, 32'h3000_0100, 4'b0001, 0, 32'h1122_3344, 0, 1,
               32'h0000_0100, 6'h39, 2'b01, 1, 0, 32'h0000_0033);
        access("R2 A32 D32 write", 1, 32'h4ABC_DEF0, 4'b1111, 32'h1234_5678, 0, 0, 1,
               32'h0ABC_DEF0, 6'h09, 2'b00, 0, 32'h1234_5678, 0);
        access("R4 A32 D16 read", 0, 32'h4000_0006, 4'b0011, 0, 32'h5555_AAAA, 0, 1,
               32'h0000_0006, 6'h09, 2'b00, 1, 0, 32'h0000_AAAA);
        access("R3 config read", 0, 32'h5007_FFFC, 4'b1111, 0, 32'h0000_00C3, 0, 1,
               32'h001F_FFFC, 6'h2F, 2'b00, 0, 0, 32'h0000_00C3);
        access("R1 unmapped window", 0, 32'h7000_0000, 4'b1111, 0, 32'hFFFF_FFFF, 1, 0,
               0, 0, 2'b11, 1, 0, 0);
        access("R7 odd D16", 0, 32'h0000_0011, 4'b0011, 0, 32'hFFFF_FFFF, 1, 0,
               0, 0, 2'b11, 1, 0, 0);
        access("R7 unaligned D32 write", 1, 32'h4000_0002, 4'b1111, 32'h0BAD_0BAD, 0, 1, 0,
               0, 0, 2'b11, 1, 0, 0);

        slv_mode = 1;
        access("R10 bus error read", 0, 32'h4000_0100, 4'b1111, 0, 32'hDEAD_DEAD, 1, 1,
               32'h0000_0100, 6'h09, 2'b00, 0, 0, 0);

        slv_mode = 2;
        access("R11 timeout read", 0, 32'h4000_0200, 4'b1111, 0, 32'hDEAD_DEAD, 1, 1,
               32'h0000_0200, 6'h09, 2'b00, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(ds_len == TMO, "R11 strobe length", ds_len, TMO);

        slv_mode = 0; slv_hold = 6; slv_delay = 0;
        access("R12 held ack write", 1, 32'h0000_0002, 4'b0011, 32'h0000_7E57, 0, 0, 1,
               32'h0000_0002, 6'h29, 2'b00, 1, 32'h0000_7E57, 0);
        slv_hold = 0;
        access("R12 follow-up read", 0, 32'h1000_0004, 4'b1111, 0, 32'h0102_0304, 0, 1,
               32'h0000_0004, 6'h29, 2'b00, 0, 0, 32'h0102_0304);
        chk(r12_viol == 0, "R12 strobe while slave busy", r12_viol, 0);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R9 outstanding responses", sb_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule